// File: doc/BRIEF.md
# Recursive Frame Averaging Controller

This block smooths a stream of pixels, one per pixel clock, against the frame that came before. The previous frame is kept in an external static RAM. An address counter is cleared by the frame sync and steps once per pixel clock. Within each clock period the block does three things at that address:

- It reads the stored pixel while the clock is high.
- It forms the rounded mean of the stored pixel and the arriving pixel.
- It writes that mean back while the clock is low and passes it downstream.

The output therefore keeps the rate of the input, with no gaps. The frame sync is presented together with the first pixel of each frame. Nothing happens before the first frame sync after reset. The first frame after reset has nothing to average against, so it passes through unchanged and fills the memory.

Top module: `frame_avg_ctrl`

## Requirements
- R1: While reset is held and after reset until the first frame sync, `sram_re`, `sram_we` and `pix_out_vld` stay 0 and `sram_addr` is 0.
- R2: A pixel presented with `fsync` high is given address 0, whatever the counter held before. A sync takes priority over counting.
- R3: Each later pixel of a frame gets the previous address plus one. When END_MODE is wrap (the default), the address after FRAME_PIX-1 is 0.
- R4: When END_MODE is hold, the address stays at FRAME_PIX-1 for any extra pixels until the next sync.
- R5: `sram_addr` is the same in the high and low halves of a pixel period.
- R6: Once the block is active, `sram_re` is high exactly while `clk` is high and `sram_we` is high exactly while `clk` is low. The two are never high together.
- R7: From the second frame onwards the result is (stored + incoming + 1) >> 1 on 8-bit unsigned pixels. The result is always 8 bits, so 255 and 255 give 255, and 0 and 1 give 1.
- R8: The value on `sram_wdata` during the low half goes to the current address, and it equals the pixel later shown on `pix_out`.
- R9: A pixel sampled at rising edge t appears on `pix_out` with `pix_out_vld` high after rising edge t+1. There is one output per pixel clock. `pix_out_sof` is high on the output of a pixel that arrived with `fsync`.
- R10: In the first frame after reset, `pix_out` equals the incoming pixel, and the incoming pixel is the value written to memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; its high half reads, its low half writes |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | High with the first pixel of a frame |
| pix_in | input | PIX_W | Incoming pixel |
| sram_addr | output | ADDR_W | Memory address, one per pixel period |
| sram_rdata | input | PIX_W | Data read from memory |
| sram_wdata | output | PIX_W | Data written to memory |
| sram_re | output | 1 | Memory read enable (high half) |
| sram_we | output | 1 | Memory write enable (low half) |
| pix_out | output | PIX_W | Averaged pixel to the frame store writer |
| pix_out_vld | output | 1 | `pix_out` holds a pixel |
| pix_out_sof | output | 1 | `pix_out` is the first pixel of a frame |

## Verification
Two things can land on the same pixel clock:

- A frame sync can arrive in the cycle where the address counter would otherwise step, wrap or sit saturated at its last location.
- The second sync after reset both clears the counter and ends the pass-through frame.

The bench provokes these cases in three ways:

- It cuts a frame short after a few pixels and re-syncs.
- It overruns a frame past its size before the next sync, on a wrapping instance and a holding instance driven side by side.
- It places the pass-through exit on the same pixel as the sync.

In each case the address and the written value of that pixel are compared with an independent model of the counter and of the stored frame.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
  typedef enum logic {FA_WRAP = 1'b0, FA_HOLD = 1'b1} fa_end_e;
endpackage

// File: rtl/fa_addr_gen.sv
`timescale 1ns/1ps
module fa_addr_gen
  import fa_pkg::*;
#(
  parameter int      ADDR_W    = 18,
  parameter int      FRAME_PIX = 1024,
  parameter fa_end_e END_MODE  = FA_WRAP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              run,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_PIX - 1);

  logic              at_last;
  logic [ADDR_W-1:0] nxt;

  assign at_last = (addr == LAST);

  generate
    if (END_MODE == FA_WRAP) begin : g_wrap
      assign nxt = at_last ? '0 : addr + 1'b1;
    end else begin : g_hold
      assign nxt = at_last ? LAST : addr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        addr <= '0;
    else if (fsync) addr <= '0;
    else if (run)   addr <= nxt;
  end
endmodule

// File: rtl/fa_blend.sv
`timescale 1ns/1ps
module fa_blend #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] prior,
  input  logic [PIX_W-1:0] fresh,
  input  logic             pass,
  output logic [PIX_W-1:0] mixed
);
  logic [PIX_W:0] sum;

  assign sum   = {1'b0, prior} + {1'b0, fresh} + {{PIX_W{1'b0}}, 1'b1};
  assign mixed = pass ? fresh : sum[PIX_W:1];
endmodule

// File: rtl/fa_wb_stage.sv
`timescale 1ns/1ps
module fa_wb_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             sof_in,
  input  logic [PIX_W-1:0] mixed,
  output logic [PIX_W-1:0] wb_data,
  output logic             wb_sof,
  output logic             wb_vld
);
  // captured at the middle of the pixel period, after the read half
  always_ff @(negedge clk) begin
    if (rst) begin
      wb_data <= '0;
      wb_sof  <= 1'b0;
      wb_vld  <= 1'b0;
    end else if (act) begin
      wb_data <= mixed;
      wb_sof  <= sof_in;
      wb_vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_avg_ctrl.sv
`timescale 1ns/1ps
module frame_avg_ctrl
  import fa_pkg::*;
#(
  parameter int      PIX_W     = 8,
  parameter int      ADDR_W    = 18,
  parameter int      FRAME_PIX = 1024,
  parameter fa_end_e END_MODE  = FA_WRAP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic [PIX_W-1:0]  pix_in,
  output logic [ADDR_W-1:0] sram_addr,
  input  logic [PIX_W-1:0]  sram_rdata,
  output logic [PIX_W-1:0]  sram_wdata,
  output logic              sram_re,
  output logic              sram_we,
  output logic [PIX_W-1:0]  pix_out,
  output logic              pix_out_vld,
  output logic              pix_out_sof
);
  logic             started;
  logic             bypass;
  logic [PIX_W-1:0] pix_q;
  logic             sof_q;
  logic [PIX_W-1:0] mixed;
  logic [PIX_W-1:0] wb_data;
  logic             wb_sof;
  logic             wb_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      bypass  <= 1'b1;
      pix_q   <= '0;
      sof_q   <= 1'b0;
    end else begin
      if (fsync) begin
        started <= 1'b1;
        bypass  <= ~started;
      end
      pix_q <= pix_in;
      sof_q <= fsync;
    end
  end

  fa_addr_gen #(
    .ADDR_W   (ADDR_W),
    .FRAME_PIX(FRAME_PIX),
    .END_MODE (END_MODE)
  ) u_addr (
    .clk  (clk),
    .rst  (rst),
    .fsync(fsync),
    .run  (started),
    .addr (sram_addr)
  );

  fa_blend #(.PIX_W(PIX_W)) u_blend (
    .prior(sram_rdata),
    .fresh(pix_q),
    .pass (bypass),
    .mixed(mixed)
  );

  fa_wb_stage #(.PIX_W(PIX_W)) u_wb (
    .clk    (clk),
    .rst    (rst),
    .act    (started),
    .sof_in (sof_q),
    .mixed  (mixed),
    .wb_data(wb_data),
    .wb_sof (wb_sof),
    .wb_vld (wb_vld)
  );

  // read strobe in the high half, write strobe in the low half
  assign sram_re    = started & clk;
  assign sram_we    = started & ~clk;
  assign sram_wdata = wb_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out     <= '0;
      pix_out_vld <= 1'b0;
      pix_out_sof <= 1'b0;
    end else begin
      pix_out     <= wb_data;
      pix_out_vld <= wb_vld;
      pix_out_sof <= wb_sof;
    end
  end
endmodule

// File: rtl/fa_avg_chk.sv
`timescale 1ns/1ps
module fa_avg_chk
  import fa_pkg::*;
#(
  parameter int      PIX_W     = 8,
  parameter int      ADDR_W    = 18,
  parameter int      FRAME_PIX = 1024,
  parameter fa_end_e END_MODE  = FA_WRAP
) (
  input logic              clk,
  input logic              rst,
  input logic              fsync,
  input logic              started,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [PIX_W-1:0]  sram_wdata,
  input logic [PIX_W-1:0]  pix_out,
  input logic              pix_out_vld
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_PIX - 1);

  // R2
  sync_zero_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> sram_addr == '0);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !fsync && sram_addr != LAST) |=> sram_addr == $past(sram_addr) + 1'b1);

  generate
    if (END_MODE == FA_WRAP) begin : g_wrap_chk
      // R3
      addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (started && !fsync && sram_addr == LAST) |=> sram_addr == '0);
    end else begin : g_hold_chk
      // R4
      addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (started && !fsync && sram_addr == LAST) |=> sram_addr == LAST);
    end
  endgenerate

  // R9
  out_vld_chk: assert property (@(posedge clk) disable iff (rst)
    started |=> pix_out_vld);

  // R8
  wb_match_chk: assert property (@(negedge clk) disable iff (rst)
    pix_out_vld |-> pix_out == sram_wdata);
endmodule

bind frame_avg_ctrl fa_avg_chk #(
  .PIX_W    (PIX_W),
  .ADDR_W   (ADDR_W),
  .FRAME_PIX(FRAME_PIX),
  .END_MODE (END_MODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fsync      (fsync),
  .started    (started),
  .sram_addr  (sram_addr),
  .sram_wdata (sram_wdata),
  .pix_out    (pix_out),
  .pix_out_vld(pix_out_vld)
);

// File: tb/frame_avg_ctrl_test.sv
`timescale 1ns/1ps
module frame_avg_ctrl_test;
  import fa_pkg::*;

  localparam int F  = 16;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fsync = 1'b0;
  logic [7:0]    pix_in = '0;
  logic [AW-1:0] sram_addr, sat_addr;
  logic [7:0]    sram_rdata, sram_wdata, sat_wdata;
  logic          sram_re, sram_we, sat_re, sat_we;
  logic [7:0]    pix_out, sat_out;
  logic          pix_out_vld, pix_out_sof, sat_vld, sat_sof;

  logic [7:0] mem [F];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // model state
  int m_addr, s_addr, shadow[F];
  bit m_started, m_byp;
  bit p_vld, p_sof;
  int p_pix;
  string p_tag;

  always #2 clk = ~clk;

  frame_avg_ctrl #(.PIX_W(8), .ADDR_W(AW), .FRAME_PIX(F), .END_MODE(FA_WRAP)) uut (
    .clk(clk), .rst(rst), .fsync(fsync), .pix_in(pix_in),
    .sram_addr(sram_addr), .sram_rdata(sram_rdata), .sram_wdata(sram_wdata),
    .sram_re(sram_re), .sram_we(sram_we),
    .pix_out(pix_out), .pix_out_vld(pix_out_vld), .pix_out_sof(pix_out_sof)
  );

  frame_avg_ctrl #(.PIX_W(8), .ADDR_W(AW), .FRAME_PIX(F), .END_MODE(FA_HOLD)) uut_sat (
    .clk(clk), .rst(rst), .fsync(fsync), .pix_in(pix_in),
    .sram_addr(sat_addr), .sram_rdata(8'h00), .sram_wdata(sat_wdata),
    .sram_re(sat_re), .sram_we(sat_we),
    .pix_out(sat_out), .pix_out_vld(sat_vld), .pix_out_sof(sat_sof)
  );

  // external memory model: read in high half, write in the low half
  assign sram_rdata = mem[sram_addr[3:0]];
  always @(negedge clk) begin
    #1;
    if (sram_we) mem[sram_addr[3:0]] = sram_wdata;
  end

  initial for (int i = 0; i < F; i++) mem[i] = 8'h00;

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endfunction

  task automatic push(input bit fs, input int px);
    int exp_v;
    int a_hi;
    fsync  = fs;
    pix_in = px[7:0];
    exp_v  = 0;
    @(posedge clk); #1;
    if (fs) begin
      m_addr = 0; s_addr = 0; m_byp = !m_started; m_started = 1;
    end else if (m_started) begin
      m_addr = (m_addr == F-1) ? 0 : m_addr + 1;
      s_addr = (s_addr == F-1) ? F-1 : s_addr + 1;
    end
    chk(pix_out_vld == p_vld, "R9", pix_out_vld, p_vld);
    if (p_vld) begin
      chk(pix_out == p_pix[7:0], p_tag, pix_out, p_pix);
      chk(pix_out_sof == p_sof, "R9", pix_out_sof, p_sof);
    end
    chk(sram_addr == AW'(m_addr), fs ? "R2" : "R3", sram_addr, m_addr);
    chk(sat_addr == AW'(s_addr), "R4", sat_addr, s_addr);
    chk(sram_re == m_started && !sram_we, "R6", sram_re, m_started);
    a_hi = sram_addr;
    if (m_started) begin
      exp_v = m_byp ? px : (shadow[m_addr] + px + 1) >> 1;
      shadow[m_addr] = exp_v;
    end
    @(negedge clk); #1;
    chk(sram_we == m_started && !sram_re, "R6", sram_we, m_started);
    chk(sram_addr == AW'(a_hi), "R5", sram_addr, a_hi);
    if (m_started) chk(sram_wdata == exp_v[7:0], "R8", sram_wdata, exp_v);
    p_vld = m_started;
    p_pix = exp_v;
    p_sof = fs;
    p_tag = m_byp ? "R10" : "R7";
  endtask

  task automatic t_reset();
    rst = 1'b1; fsync = 1'b0;
    m_started = 0; m_byp = 1; m_addr = 0; s_addr = 0; p_vld = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(sram_re == 1'b0, "R1", sram_re, 0);
    chk(pix_out_vld == 1'b0, "R1", pix_out_vld, 0);
    chk(sram_addr == '0, "R1", sram_addr, 0);
    @(negedge clk); #1;
    chk(sram_we == 1'b0, "R1", sram_we, 0);
    rst = 1'b0;
  endtask

  task automatic t_idle();
    // R1: no access before the first sync
    for (int i = 0; i < 3; i++) push(1'b0, 8'hA5);
    chk(pix_out_vld == 1'b0, "R1", pix_out_vld, 0);
  endtask

  task automatic t_bypass_frame();
    // R10: first frame passes through; includes 255 and 0
    for (int i = 0; i < F; i++) push(i == 0, (i == 0) ? 255 : (i == 1) ? 0 : (i * 37 + 5) & 255);
  endtask

  task automatic t_average_frame();
    // R7: second sync ends pass-through on the same pixel
    for (int i = 0; i < F; i++) push(i == 0, (i == 0) ? 255 : (i == 1) ? 1 : (i * 91 + 17) & 255);
  endtask

  task automatic t_round_frame();
    // R7: rounding corners around 0 and 255
    for (int i = 0; i < F; i++) push(i == 0, (i % 4 == 0) ? 0 : (i % 4 == 1) ? 255 : (i % 4 == 2) ? 1 : 254);
  endtask

  task automatic t_short_frame();
    // R2: sync cuts a frame after five pixels
    for (int i = 0; i < 5; i++) push(i == 0, 40 + i * 7);
    for (int i = 0; i < 4; i++) push(i == 0, 200 - i * 9);
  endtask

  task automatic t_overrun_frame();
    // R3 wraps, R4 holds: frame longer than F, then sync at the held top
    for (int i = 0; i < F + 4; i++) push(i == 0, (i * 13 + 99) & 255);
    push(1'b1, 77);
    for (int i = 0; i < 2; i++) push(1'b0, 120 + i);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_idle();
    t_bypass_frame();
    t_average_frame();
    t_round_frame();
    t_short_frame();
    t_overrun_frame();
    push(1'b0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule